// File: doc/BRIEF.md
# Supply Domain Isolation Sequencer

This block decides when three separately powered regions of a chip may leave isolation: the USB supply region, a secondary I/O bank region and the analog region. Each region has its own supply monitor. The monitor raises a flag while the supply sits below its threshold. Before the isolation of a region may be lifted, the block steps through a fixed bring-up order for it. It first switches the monitor on. It then lets the monitor settle for a programmed number of cycles. Next it waits for the below-threshold flag to go low. If the option is set, it then switches the monitor off again. Only after all of that does it declare the region's supply valid.

Each region runs its own state machine from one clock and a synchronous active-high reset. The USB and I/O regions leave isolation as soon as their supply is declared valid. The analog region has two monitors, and one of them is picked per bring-up. Its isolation is lifted only while the supply is valid and an analog peripheral enable is also present. If a monitor never reports a good supply within a fixed number of checks, that region is aborted, a sticky error is raised and isolation stays on. Withdrawing a request returns the region to idle and re-isolates it.

Top module: `supply_iso_seq`

## Requirements
- R1: After reset every region is isolated (`iso` = 3'b111). `dom_ok`, `mon_en`, `busy` and `err` are all zero.
- R2: On the first clock edge that samples `dom_req[d]` high while the region is idle, the monitor of that region is enabled and `busy[d]` goes high.
- R3: With a wakeup length N on `wake_len`, the monitor flag is not evaluated during the N cycles that follow the request edge. If the flag is already clear, `dom_ok[d]` rises on edge N+2, counting the request edge as edge 1. N = 0 means no wait.
- R4: After the wakeup wait, the flag is checked once per cycle. `dom_ok[d]` rises on the edge after the first check that sees the flag low. Until then `busy[d]` stays high and `dom_ok[d]` stays low.
- R5: When the supply is confirmed, the monitor of the region is switched off if `mon_off_req[d]` = 1 and stays on if it is 0.
- R6: For regions 0 (USB) and 1 (I/O), `iso[d]` is the inverse of `dom_ok[d]`.
- R7: For region 2 (analog), `iso[2]` is low only while `dom_ok[2]` and `ana_periph_en` are both high. It follows `ana_periph_en` without a clock delay.
- R8: Region 2 uses monitor bit 2 when `ana_pick` = 0 and monitor bit 3 when `ana_pick` = 1. The choice is captured when the region starts. Only the chosen monitor is enabled, and only the chosen monitor's flag counts.
- R9: If the flag is still high at the TIMEOUT-th check, the region aborts on that edge. `err[d]` is set, the monitor is switched off, `dom_ok[d]` stays low and `iso[d]` stays high. A flag that clears exactly at the last check still succeeds.
- R10: If `dom_req[d]` is sampled low in any state, the next edge returns the region to idle. `dom_ok[d]` goes low, the monitor goes off, `busy[d]` goes low and `iso[d]` goes high.
- R11: The regions are independent. Concurrent requests with different wakeup lengths each complete on their own schedule.
- R12: `err[d]` stays set until reset, including through later requests that succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dom_req | input | 3 | Bring-up request per region (0 USB, 1 I/O, 2 analog) |
| mon_off_req | input | 3 | Switch the monitor off after the supply is confirmed |
| wake_len | input | 3*WAKE_W | Wakeup cycle count per region; region d uses bits [d*WAKE_W +: WAKE_W] |
| ana_pick | input | 1 | Selects which of the two analog monitors is used |
| ana_periph_en | input | 1 | Analog peripheral enable; lifts analog isolation once the supply is valid |
| mon_low | input | 4 | Below-threshold flags: USB, I/O, analog A, analog B |
| mon_en | output | 4 | Monitor enables, in the same bit order as `mon_low` |
| dom_ok | output | 3 | Supply declared valid per region |
| iso | output | 3 | Isolation active per region |
| busy | output | 3 | Region is waiting for wakeup or for the flag |
| err | output | 3 | Sticky timeout error per region |

## Verification
The bench sweeps every region across wakeup lengths that include zero and the largest count. For each length it holds the flag high for a range of check counts, including exactly one short of the timeout and exactly at the timeout. It then checks the edge on which the region finishes. A design that ignores the wakeup window finishes too early. A design that is off by one in the timeout compare either aborts a bring-up that should succeed or lets through one that should fail. For the analog region, the flag of the monitor that was not chosen is held high. A design that routes the wrong monitor then never finishes, or enables the wrong bit. The bench also withdraws a request in the middle of the wakeup wait, runs two regions at once, and checks that an earlier error survives a later success.

// File: rtl/iso_seq_pkg.sv
package iso_seq_pkg;

  localparam int NUM_DOM = 3;
  localparam int NUM_MON = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAKE  = 3'd1,
    ST_CHECK = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } dom_state_t;

endpackage

// File: rtl/iso_dom_ctrl.sv
module iso_dom_ctrl
  import iso_seq_pkg::*;
#(
  parameter int WAKE_W  = 8,
  parameter int TIMEOUT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              mon_off,
  input  logic [WAKE_W-1:0] wake_len,
  input  logic              mon_low,
  output logic              mon_en,
  output logic              ok,
  output logic              busy,
  output logic              err,
  output logic              idle
);

  localparam int TMO_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam int CNT_W = (WAKE_W > TMO_W) ? WAKE_W : TMO_W;
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT - 1);

  dom_state_t       st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      mon_en <= 1'b0;
      ok     <= 1'b0;
      err    <= 1'b0;
    end else if (!req) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      mon_en <= 1'b0;
      ok     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          mon_en <= 1'b1;
          if (wake_len == '0) begin
            st  <= ST_CHECK;
            cnt <= '0;
          end else begin
            st  <= ST_WAKE;
            cnt <= CNT_W'(wake_len) - CNT_W'(1);
          end
        end
        ST_WAKE: begin
          if (cnt == '0) begin
            st <= ST_CHECK;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_CHECK: begin
          if (!mon_low) begin
            st <= ST_DONE;
            ok <= 1'b1;
            if (mon_off) mon_en <= 1'b0;
          end else if (cnt == TMO_LAST) begin
            st     <= ST_FAULT;
            err    <= 1'b1;
            mon_en <= 1'b0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign busy = (st == ST_WAKE) || (st == ST_CHECK);
  assign idle = (st == ST_IDLE);

  p_drop_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!ok && !mon_en && !busy));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_ok_after_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ok) |-> $past(!mon_low));

  p_wake_no_ok_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAKE) |-> (mon_en && !ok));

  p_ok_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
    ok |-> $past(req));

endmodule

// File: rtl/iso_mon_pick.sv
module iso_mon_pick (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       pick,
  input  logic       en_in,
  input  logic [1:0] low_in,
  output logic [1:0] en_out,
  output logic       low_out
);

  logic pick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pick_q <= 1'b0;
    end else if (load) begin
      pick_q <= pick;
    end
  end

  assign en_out  = {en_in & pick_q, en_in & ~pick_q};
  assign low_out = pick_q ? low_in[1] : low_in[0];

  p_single_mon_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(en_in) |-> (pick_q == $past(pick)));

endmodule

// File: rtl/supply_iso_seq.sv
module supply_iso_seq
  import iso_seq_pkg::*;
#(
  parameter int WAKE_W  = 8,
  parameter int TIMEOUT = 1000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            dom_req,
  input  logic [2:0]            mon_off_req,
  input  logic [3*WAKE_W-1:0]   wake_len,
  input  logic                  ana_pick,
  input  logic                  ana_periph_en,
  input  logic [3:0]            mon_low,
  output logic [3:0]            mon_en,
  output logic [2:0]            dom_ok,
  output logic [2:0]            iso,
  output logic [2:0]            busy,
  output logic [2:0]            err
);

  logic [NUM_DOM-1:0] dom_low;
  logic [NUM_DOM-1:0] dom_en;
  logic [NUM_DOM-1:0] dom_idle;
  logic [1:0]         ana_en;
  logic               ana_low;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    if (d == NUM_DOM - 1) begin : g_ana_in
      assign dom_low[d] = ana_low;
    end else begin : g_plain_in
      assign dom_low[d] = mon_low[d];
    end

    iso_dom_ctrl #(
      .WAKE_W  (WAKE_W),
      .TIMEOUT (TIMEOUT)
    ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .req      (dom_req[d]),
      .mon_off  (mon_off_req[d]),
      .wake_len (wake_len[d*WAKE_W +: WAKE_W]),
      .mon_low  (dom_low[d]),
      .mon_en   (dom_en[d]),
      .ok       (dom_ok[d]),
      .busy     (busy[d]),
      .err      (err[d]),
      .idle     (dom_idle[d])
    );
  end

  iso_mon_pick u_pick (
    .clk     (clk),
    .rst     (rst),
    .load    (dom_idle[2]),
    .pick    (ana_pick),
    .en_in   (dom_en[2]),
    .low_in  (mon_low[3:2]),
    .en_out  (ana_en),
    .low_out (ana_low)
  );

  assign mon_en = {ana_en, dom_en[1:0]};
  assign iso    = {~(dom_ok[2] & ana_periph_en), ~dom_ok[1:0]};

  p_iso_on_err_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(err[0]) |-> iso[0]) and ($rose(err[1]) |-> iso[1]) and ($rose(err[2]) |-> iso[2]));

endmodule

// File: tb/tb_supply_iso_seq.sv
module tb_supply_iso_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WW  = 4;
  localparam int TMO = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    dom_req;
  logic [2:0]    mon_off_req;
  logic [3*WW-1:0] wake_len;
  logic          ana_pick;
  logic          ana_periph_en;
  logic [3:0]    mon_low;
  logic [3:0]    mon_en;
  logic [2:0]    dom_ok;
  logic [2:0]    iso;
  logic [2:0]    busy;
  logic [2:0]    err;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] err_exp = 3'b000;

  supply_iso_seq #(.WAKE_W(WW), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst(rst), .dom_req(dom_req), .mon_off_req(mon_off_req),
    .wake_len(wake_len), .ana_pick(ana_pick), .ana_periph_en(ana_periph_en),
    .mon_low(mon_low), .mon_en(mon_en), .dom_ok(dom_ok), .iso(iso),
    .busy(busy), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit good, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int mon_idx(input int d, input bit p);
    if (d < 2) return d;
    return p ? 3 : 2;
  endfunction

  task automatic run_one(input int d, input int n, input int k, input bit opt, input bit p);
    int mi;
    int exp_e;
    int end_e;
    bit exp_ok;
    mi = mon_idx(d, p);
    wake_len[d*WW +: WW] = WW'(n);
    mon_off_req[d] = opt;
    ana_pick = p;
    mon_low = 4'hF;
    dom_req[d] = 1'b1;
    exp_ok = (k <= TMO - 1);
    exp_e  = exp_ok ? (n + 2 + k) : (n + TMO + 1);
    end_e  = -1;
    for (int e = 1; e <= 40; e++) begin
      cyc();
      if (e == 1) begin
        check(mon_en[mi] == 1'b1 && busy[d] == 1'b1, "R2 monitor on at request", int'(mon_en[mi]), 1);
        if (d == 2)
          check(mon_en[5 - mi] == 1'b0, "R8 unpicked monitor off", int'(mon_en[5 - mi]), 0);
      end
      if (busy[d] == 1'b0) begin
        end_e = e;
        break;
      end
      mon_low[mi] = (e < n + 1 + k) ? 1'b1 : 1'b0;
    end
    check(end_e == exp_e, exp_ok ? "R3 R4 finish edge" : "R9 timeout edge", end_e, exp_e);
    if (exp_ok) begin
      check(dom_ok[d] == 1'b1, "R4 supply valid", int'(dom_ok[d]), 1);
      check(mon_en[mi] == !opt, "R5 monitor after confirm", int'(mon_en[mi]), int'(!opt));
      if (d < 2) begin
        check(iso[d] == 1'b0, "R6 isolation lifted", int'(iso[d]), 0);
      end else begin
        check(iso[2] == 1'b1, "R7 analog iso without enable", int'(iso[2]), 1);
        ana_periph_en = 1'b1;
        #1;
        check(iso[2] == 1'b0, "R7 analog iso with enable", int'(iso[2]), 0);
        ana_periph_en = 1'b0;
        #1;
      end
    end else begin
      err_exp[d] = 1'b1;
      check(dom_ok[d] == 1'b0 && mon_en[mi] == 1'b0 && iso[d] == 1'b1,
            "R9 abort keeps isolation", int'({dom_ok[d], mon_en[mi], iso[d]}), 1);
    end
    check(err[d] == err_exp[d], "R12 sticky error", int'(err[d]), int'(err_exp[d]));
    dom_req[d] = 1'b0;
    cyc();
    check(dom_ok[d] == 1'b0 && mon_en[mi] == 1'b0 && iso[d] == 1'b1 && busy[d] == 1'b0,
          "R10 drop returns to idle", int'({dom_ok[d], mon_en[mi], iso[d], busy[d]}), 2);
    mon_low = 4'hF;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e0;
    int e1;
    rst = 1'b1;
    dom_req = 3'b000;
    mon_off_req = 3'b000;
    wake_len = '0;
    ana_pick = 1'b0;
    ana_periph_en = 1'b0;
    mon_low = 4'hF;
    cyc(); cyc(); cyc();
    rst = 1'b0;
    cyc();
    check(iso == 3'b111 && dom_ok == 3'b000 && mon_en == 4'h0 && busy == 3'b000 && err == 3'b000,
          "R1 reset state", int'({iso, dom_ok, mon_en, busy, err}), 7 << 13);

    for (int d = 0; d < 3; d++) begin
      for (int ni = 0; ni < 5; ni++) begin
        for (int ki = 0; ki < 5; ki++) begin
          for (int o = 0; o < 2; o++) begin
            int n;
            int k;
            n = (ni == 0) ? 0 : (ni == 1) ? 1 : (ni == 2) ? 2 : (ni == 3) ? 5 : 15;
            k = (ki == 0) ? 0 : (ki == 1) ? 1 : (ki == 2) ? 3 : (ki == 3) ? TMO - 1 : TMO;
            run_one(d, n, k, o[0], (ni + o) % 2 == 1);
          end
        end
      end
    end

    // R10: withdraw during the wakeup wait
    wake_len[0 +: WW] = WW'(5);
    dom_req[0] = 1'b1;
    cyc(); cyc();
    dom_req[0] = 1'b0;
    cyc();
    check(busy[0] == 1'b0 && mon_en[0] == 1'b0 && iso[0] == 1'b1,
          "R10 drop during wakeup", int'({busy[0], mon_en[0], iso[0]}), 1);

    // R11: two regions at once
    wake_len[0 +: WW] = WW'(3);
    wake_len[WW +: WW] = WW'(0);
    mon_low = 4'h0;
    mon_off_req = 3'b000;
    dom_req = 3'b011;
    e0 = -1;
    e1 = -1;
    for (int e = 1; e <= 12; e++) begin
      cyc();
      if (e0 < 0 && dom_ok[0]) e0 = e;
      if (e1 < 0 && dom_ok[1]) e1 = e;
    end
    check(e0 == 5, "R11 region 0 schedule", e0, 5);
    check(e1 == 2, "R11 region 1 schedule", e1, 2);
    check(dom_ok[2] == 1'b0 && mon_en[3:2] == 2'b00, "R11 idle region untouched",
          int'({dom_ok[2], mon_en[3:2]}), 0);
    dom_req = 3'b000;
    mon_low = 4'hF;
    cyc();

    // R12: error survives until reset
    check(err == err_exp, "R12 errors before reset", int'(err), int'(err_exp));
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    cyc();
    check(err == 3'b000, "R12 reset clears error", int'(err), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule